// File: doc/BRIEF.md
# DRAM Mode Register Command Handler

This block sits on the device side of a graphics DRAM command interface. It decodes the mode register set command from the chip-select, row strobe, column strobe and write enable pins. When bank address bit 0 selects this register and the device reports idle, it captures the address bus into the mode register. From the stored value it drives the burst length, CAS latency and write latency as binary cycle counts, together with a test-mode flag and a one-cycle DLL reset pulse.

The register has no usable value after power-up. Until the first legal write, a programmed flag stays low and every decoded output reads zero. After each write taken while idle, the block lowers command-ready for a programmable number of cycles. Any command that arrives inside that window is flagged and ignored. Writes that carry a reserved code are rejected and flagged, and the last legal settings stay in force. Writes issued outside the idle state are also rejected and flagged.

Top module: `mrs_ctl`

## Requirements
- R1: After synchronous active-low reset: `programmed`=0, `cmd_ready`=1, `dll_rst`=0, all three error flags are 0, and `burst_len`, `cas_lat`, `wr_lat` and `test_mode` are 0.
- R2: A mode register write is decoded on a rising edge when `cke`=1, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 0, and `ba[0]`=0. `ba[2:1]` are ignored. With `ba[0]`=1, or with `cke`=0, the register and all flags are left unchanged.
- R3: A legal write taken while idle updates the outputs after the capture edge and sets `programmed`. The fields are decoded as follows:
  - `addr[1:0]`: 2'b10 gives burst 4, 2'b11 gives burst 8.
  - `addr[3]`: burst type, where 0 means sequential.
  - `addr[6:4]`: 3'b011..3'b111 give CAS latency 7..11.
  - `addr[7]`: test mode.
  - `addr[8]`: DLL reset.
  - `addr[11:9]`: 3'b001..3'b110 give write latency 1..6.
  - `addr[2]` is ignored.
- R4: While `programmed`=0, `burst_len`, `cas_lat`, `wr_lat` and `test_mode` read 0.
- R5: A write taken while idle with any reserved code sets the sticky `err_reserved`. Reserved codes are burst code 00 or 01, burst type 1, CAS code 000..010, and write-latency code 000 or 111. Such a write changes neither the decoded outputs nor `programmed`, and raises no DLL pulse.
- R6: A write issued while `dev_idle`=0 sets the sticky `err_state`. It changes no output and starts no lockout.
- R7: A write taken while idle, legal or reserved, holds `cmd_ready` low for exactly `tmrd_cyc` cycles after the capture edge. With `tmrd_cyc`=0 there is no lockout.
- R8: Any command seen while `cmd_ready`=0 sets the sticky `err_tmrd` and is not acted on. A command is `cke`=1 and `cs_n`=0 with at least one of the three strobes low.
- R9: A legal write with `addr[8]`=1 drives `dll_rst` high for exactly the one cycle after the capture edge. The stored bit then clears itself.
- R10: The error flags and `programmed` are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address; bit 0 selects the register |
| addr | input | 12 | Address bus carrying the register code |
| dev_idle | input | 1 | Device is in the idle state |
| tmrd_cyc | input | 4 | Lockout length in cycles after a write |
| cmd_ready | output | 1 | High when a new command may be issued |
| programmed | output | 1 | A legal write has happened since reset |
| burst_len | output | 4 | Burst length, 4 or 8 (0 when unprogrammed) |
| cas_lat | output | 4 | CAS latency in cycles |
| wr_lat | output | 3 | Write latency in cycles |
| test_mode | output | 1 | Test mode selected |
| dll_rst | output | 1 | One-cycle DLL reset pulse |
| err_reserved | output | 1 | Sticky: a reserved code was written |
| err_state | output | 1 | Sticky: a write was issued while not idle |
| err_tmrd | output | 1 | Sticky: a command arrived during the lockout |

## Verification
The checker runs every cycle against the internal take and violation strobes. It confirms the following:
- the DLL pulse never lasts two cycles;
- the outputs stay zero before programming;
- a programmed burst length is always 4 or 8;
- the error flags never fall;
- reserved, non-idle and early writes leave the latencies stable;
- a taken write drops command-ready.

Only the directed scenarios can show three things. The first is that each field code maps to the right cycle count. The second is that the lockout lasts exactly the programmed number of cycles. The third is that `ba[2:1]` and `addr[2]` are ignored.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int BL_W = 4;
  localparam int CL_W = 4;
  localparam int WL_W = 3;

  typedef struct packed {
    logic [BL_W-1:0] bl;
    logic [CL_W-1:0] cl;
    logic [WL_W-1:0] wl;
    logic            tm;
    logic            dll;
    logic            ok;
  } mode_t;

  // burst code -> beats, 0 marks reserved
  function automatic logic [BL_W-1:0] bl_of(input logic [1:0] c);
    case (c)
      2'b10:   return BL_W'(4);
      2'b11:   return BL_W'(8);
      default: return '0;
    endcase
  endfunction

  // CAS code 3..7 -> latency 7..11, 0 marks reserved
  function automatic logic [CL_W-1:0] cl_of(input logic [2:0] c);
    if (c >= 3'd3) return CL_W'(c) + CL_W'(4);
    return '0;
  endfunction

  // write latency code 1..6 -> same count, 0 marks reserved
  function automatic logic [WL_W-1:0] wl_of(input logic [2:0] c);
    if (c == 3'd0 || c == 3'd7) return '0;
    return WL_W'(c);
  endfunction
endpackage

// File: rtl/mrs_cmd_decode.sv
module mrs_cmd_decode (
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ba0,
  output logic any_cmd,
  output logic mrs_sel
);
  logic nop;
  assign nop     = ras_n & cas_n & we_n;
  assign any_cmd = cke & ~cs_n & ~nop;
  assign mrs_sel = cke & ~cs_n & ~ras_n & ~cas_n & ~we_n & ~ba0;
endmodule

// File: rtl/mrs_field_decode.sv
module mrs_field_decode
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode
);
  localparam int BT_BIT  = 3;
  localparam int CL_LO   = 4;
  localparam int TM_BIT  = 7;
  localparam int DLL_BIT = 8;
  localparam int WL_LO   = 9;

  always_comb begin
    mode.bl  = bl_of(addr[1:0]);
    mode.cl  = cl_of(addr[CL_LO+2:CL_LO]);
    mode.wl  = wl_of(addr[WL_LO+2:WL_LO]);
    mode.tm  = addr[TM_BIT];
    mode.dll = addr[DLL_BIT];
    mode.ok  = (mode.bl != '0) && (mode.cl != '0) && (mode.wl != '0)
               && !addr[BT_BIT];
  end
endmodule

// File: rtl/mrs_lockout.sv
module mrs_lockout #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] len,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/mrs_ctl.sv
module mrs_ctl
  import mrs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 3,
  parameter int TMRD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dev_idle,
  input  logic [TMRD_W-1:0] tmrd_cyc,
  output logic              cmd_ready,
  output logic              programmed,
  output logic [BL_W-1:0]   burst_len,
  output logic [CL_W-1:0]   cas_lat,
  output logic [WL_W-1:0]   wr_lat,
  output logic              test_mode,
  output logic              dll_rst,
  output logic              err_reserved,
  output logic              err_state,
  output logic              err_tmrd
);
  logic  any_cmd, mrs_sel, busy;
  mode_t fmode;

  // named events for the checker
  logic cmd_early, mrs_try, mrs_bad_state, mrs_take, mrs_legal, mrs_rsvd;

  mrs_cmd_decode u_cmd (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba0(ba[0]), .any_cmd(any_cmd), .mrs_sel(mrs_sel)
  );

  mrs_field_decode #(.ADDR_W(ADDR_W)) u_fld (.addr(addr), .mode(fmode));

  mrs_lockout #(.W(TMRD_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(mrs_take), .len(tmrd_cyc), .busy(busy)
  );

  assign cmd_early     = any_cmd & busy;
  assign mrs_try       = mrs_sel & ~busy;
  assign mrs_bad_state = mrs_try & ~dev_idle;
  assign mrs_take      = mrs_try & dev_idle;
  assign mrs_legal     = mrs_take & fmode.ok;
  assign mrs_rsvd      = mrs_take & ~fmode.ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_len    <= '0;
      cas_lat      <= '0;
      wr_lat       <= '0;
      test_mode    <= 1'b0;
      dll_rst      <= 1'b0;
      programmed   <= 1'b0;
      err_reserved <= 1'b0;
      err_state    <= 1'b0;
      err_tmrd     <= 1'b0;
    end else begin
      dll_rst <= mrs_legal & fmode.dll;
      if (mrs_legal) begin
        burst_len  <= fmode.bl;
        cas_lat    <= fmode.cl;
        wr_lat     <= fmode.wl;
        test_mode  <= fmode.tm;
        programmed <= 1'b1;
      end
      if (mrs_rsvd)      err_reserved <= 1'b1;
      if (mrs_bad_state) err_state    <= 1'b1;
      if (cmd_early)     err_tmrd     <= 1'b1;
    end
  end

  assign cmd_ready = ~busy;
endmodule

// File: rtl/mrs_ctl_chk.sv
module mrs_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       programmed,
  input logic [3:0] burst_len,
  input logic [3:0] cas_lat,
  input logic [2:0] wr_lat,
  input logic       test_mode,
  input logic       dll_rst,
  input logic       err_reserved,
  input logic       err_state,
  input logic       err_tmrd,
  input logic [3:0] tmrd_cyc,
  input logic       mrs_take,
  input logic       mrs_rsvd,
  input logic       mrs_bad_state,
  input logic       cmd_early
);
  // R9
  dll_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst |=> !dll_rst);

  // R4
  unprog_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !programmed |-> (burst_len == 0 && cas_lat == 0 && wr_lat == 0 && !test_mode));

  // R3
  bl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    programmed |-> (burst_len == 4 || burst_len == 8));

  // R5
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_rsvd |=> ($stable(cas_lat) && $stable(wr_lat) && err_reserved && !dll_rst));

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_bad_state |=> ($stable(cas_lat) && $stable(burst_len) && err_state));

  // R7
  lock_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_take && tmrd_cyc != 0) |=> !cmd_ready);

  // R8
  early_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_early |=> (err_tmrd && $stable(cas_lat) && $stable(wr_lat)));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reserved || err_state || err_tmrd || programmed) |=>
      ($past(err_reserved) <= err_reserved && $past(err_state) <= err_state &&
       $past(err_tmrd) <= err_tmrd && $past(programmed) <= programmed));
endmodule

bind mrs_ctl mrs_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .programmed(programmed),
  .burst_len(burst_len), .cas_lat(cas_lat), .wr_lat(wr_lat),
  .test_mode(test_mode), .dll_rst(dll_rst), .err_reserved(err_reserved),
  .err_state(err_state), .err_tmrd(err_tmrd), .tmrd_cyc(tmrd_cyc),
  .mrs_take(mrs_take), .mrs_rsvd(mrs_rsvd), .mrs_bad_state(mrs_bad_state),
  .cmd_early(cmd_early)
);

// File: tb/mrs_ctl_tb.sv
module mrs_ctl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [2:0]  ba = 0;
  logic [11:0] addr = 0;
  logic        dev_idle = 1;
  logic [3:0]  tmrd_cyc = 4'd3;
  logic        cmd_ready, programmed, test_mode, dll_rst;
  logic        err_reserved, err_state, err_tmrd;
  logic [3:0]  burst_len, cas_lat;
  logic [2:0]  wr_lat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mrs_ctl dut_i (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // address built from wanted values: wl, dll, tm, cl, bt, beats
  function automatic logic [11:0] enc(int wl, bit dll, bit tm, int cl, bit bt, int bl);
    logic [1:0] b = (bl == 8) ? 2'b11 : 2'b10;
    logic [2:0] c = 3'(cl - 4);
    return {3'(wl), dll, tm, c, bt, 1'b0, b};
  endfunction

  // drive one command for a cycle; returns at the falling edge after capture
  task automatic cmd(bit r, bit c, bit w, logic [2:0] b, logic [11:0] a);
    cs_n = 0; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
    @(negedge clk);
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  task automatic mrs(logic [2:0] b, logic [11:0] a);
    cmd(0, 0, 0, b, a);
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic expect_mode(string req, int bl, int cl, int wl, bit tm);
    check({req, " burst_len"}, burst_len, bl);
    check({req, " cas_lat"}, cas_lat, cl);
    check({req, " wr_lat"}, wr_lat, wl);
    check({req, " test_mode"}, test_mode, tm);
  endtask

  task automatic t_reset();
    check("R1 programmed", programmed, 0);
    check("R1 cmd_ready", cmd_ready, 1);
    check("R1 dll_rst", dll_rst, 0);
    check("R1 errors", {err_reserved, err_state, err_tmrd}, 0);
    expect_mode("R1", 0, 0, 0, 0);
  endtask

  task automatic t_ignored_cmds();
    cke = 0; mrs(3'b000, enc(3, 0, 0, 9, 0, 8)); cke = 1;
    check("R2 cke low no program", programmed, 0);
    check("R2 cke low ready", cmd_ready, 1);
    mrs(3'b001, enc(3, 0, 0, 9, 0, 8));
    check("R2 ba0 high no program", programmed, 0);
    check("R2 ba0 high ready", cmd_ready, 1);
    check("R4 outputs zero", cas_lat, 0);
  endtask

  task automatic t_first_write();
    mrs(3'b110, enc(3, 1, 0, 9, 0, 8));
    check("R3 programmed", programmed, 1);
    expect_mode("R3", 8, 9, 3, 0);
    check("R9 dll pulse high", dll_rst, 1);
    check("R7 locked", cmd_ready, 0);
    @(negedge clk);
    check("R9 dll self clear", dll_rst, 0);
    check("R7 locked cycle 2", cmd_ready, 0);
    @(negedge clk);
    check("R7 locked cycle 3", cmd_ready, 0);
    @(negedge clk);
    check("R7 released after tmrd", cmd_ready, 1);
    check("R8 no early flag", err_tmrd, 0);
  endtask

  task automatic t_early();
    mrs(3'b000, enc(2, 0, 1, 7, 0, 4));
    mrs(3'b000, enc(5, 1, 0, 11, 0, 8));
    check("R8 err_tmrd", err_tmrd, 1);
    check("R8 no dll from blocked", dll_rst, 0);
    expect_mode("R8 first kept", 4, 7, 2, 1);
    settle();
  endtask

  task automatic t_not_idle();
    dev_idle = 0;
    mrs(3'b000, enc(6, 1, 0, 10, 0, 8));
    dev_idle = 1;
    check("R6 err_state", err_state, 1);
    check("R6 no lockout", cmd_ready, 1);
    check("R6 no dll", dll_rst, 0);
    expect_mode("R6 unchanged", 4, 7, 2, 1);
  endtask

  task automatic t_reserved();
    mrs(3'b000, {3'd3, 1'b1, 1'b0, 3'b010, 1'b0, 1'b0, 2'b11});
    check("R5 err_reserved cl", err_reserved, 1);
    check("R5 no dll", dll_rst, 0);
    check("R7 reserved still locks", cmd_ready, 0);
    expect_mode("R5 kept", 4, 7, 2, 1);
    settle();
    mrs(3'b000, enc(7, 0, 0, 8, 0, 8));
    expect_mode("R5 wl reserved kept", 4, 7, 2, 1);
    settle();
    mrs(3'b000, enc(2, 0, 0, 8, 1, 8));
    expect_mode("R5 bt reserved kept", 4, 7, 2, 1);
    settle();
    mrs(3'b000, {3'd2, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0, 2'b01});
    expect_mode("R5 bl reserved kept", 4, 7, 2, 1);
    settle();
  endtask

  task automatic t_encodings();
    tmrd_cyc = 0;
    for (int cl = 7; cl <= 11; cl++) begin
      for (int wl = 1; wl <= 6; wl++) begin
        logic [11:0] a = enc(wl, 0, cl[0], cl, 0, (wl % 2 == 1) ? 4 : 8);
        a[2] = wl[1];
        mrs({2'(wl), 1'b0}, a);
        check("R7 zero tmrd ready", cmd_ready, 1);
        expect_mode("R3 sweep", (wl % 2 == 1) ? 4 : 8, cl, wl, cl[0]);
      end
    end
    mrs(3'b000, enc(1, 1, 0, 8, 0, 4));
    mrs(3'b000, enc(4, 0, 0, 10, 0, 8));
    check("R7 back to back accepted", cas_lat, 10);
    check("R9 pulse not repeated", dll_rst, 0);
    check("R10 flags still set", {err_reserved, err_state, err_tmrd}, 7);
    tmrd_cyc = 3;
  endtask

  task automatic t_reset_again();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 cleared by reset", {err_reserved, err_state, err_tmrd, programmed}, 0);
    check("R1 outputs zero", {burst_len, cas_lat, wr_lat, test_mode}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ignored_cmds();
    t_first_write();
    t_early();
    t_not_idle();
    t_reserved();
    t_encodings();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule